// File: doc/BRIEF.md
# Contiguous Hit Cluster Finder

This block takes one word of strip hits, where each set bit marks a strip that fired. It reports every run of adjacent set bits in that word as a cluster record. On acceptance, the word is turned into two marker vectors, one for the upper edge and one for the lower edge of each run, and these are held in registers. After that, the block peels off one cluster per output handshake, always the one highest in the word. It clears the two edge markers it just used and repeats until no markers remain or the cluster limit is reached. The number of cycles therefore depends on how many clusters the word holds, not on how many strips it has.

Words enter on a valid/ready stream. The block accepts a word only while it is idle. Cluster records leave on a second valid/ready stream. When `out_ready` is low, the current record stays on the output unchanged for as long as needed. After the final record of a word, a one-cycle `done` pulse follows, together with an `overflow` flag. A word with no hits produces no records, and its `done` pulse comes in the cycle right after it is accepted.

Top module: `cluster_finder`

## Requirements
- R1: A word on `in_hits` is captured at a clock edge where `in_valid` and `in_ready` are both high. `in_ready` equals the inverse of `busy`. A word offered while `busy` is high is ignored and yields no records.
- R2: Strip bit i is numbered position i+1, so positions run 1 to 12 and 0 never names a strip. Each record's `out_start` is the position of the most significant bit of a run. Its `out_finish` is the position of the least significant bit of the same run. Strips beyond either end of the word count as unfired.
- R3: Records of one word come out highest run first, one record per output handshake. While `out_ready` stays high there are no idle cycles between them.
- R4: `out_width` equals start minus finish plus one, and saturates at 7 for runs longer than 7 strips.
- R5: `out_centre` equals start plus finish, which is the run centre in half-strip units.
- R6: At most MAX_CLUSTERS records (default 6) are emitted per word, and lower clusters beyond the limit are dropped. `overflow` is high during the `done` pulse exactly when clusters were dropped.
- R7: `done` is high for one cycle, in the cycle after the final record's handshake. For an all-zero word it is high in the cycle after acceptance, and no record is emitted.
- R8: While `out_valid` is high and `out_ready` is low, the record and `out_valid` hold steady.
- R9: After reset, `busy`, `out_valid`, `done` and `overflow` are all low.
- R10: `out_last` is high on the final record emitted for a word, and low on every other record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Hit word offered |
| in_ready | output | 1 | Block can take a word |
| in_hits | input | 12 | Strip hit word, bit i is position i+1 |
| busy | output | 1 | A word is being split into records |
| out_valid | output | 1 | Cluster record present |
| out_ready | input | 1 | Consumer takes the record |
| out_start | output | 4 | Upper position of the run |
| out_finish | output | 4 | Lower position of the run |
| out_centre | output | 5 | start + finish, half-strip units |
| out_width | output | 3 | Run length, saturating at 7 |
| out_last | output | 1 | Final record of this word |
| done | output | 1 | One-cycle end-of-word pulse |
| overflow | output | 1 | Clusters were dropped, valid with done |

## Verification
The bench drives words whose runs touch both ends of the word. A design that wrongly treated the strips past the ends as fired would lose the start marker on bit 11 or the finish marker on bit 0. It also uses the all-ones word and a seven-strip run to catch a width field that wraps instead of saturating. A maximally packed alternating word and a second instance with a limit of two clusters check that the count stops exactly at the limit, that the lowest runs are the ones dropped, and that overflow is raised only when runs were actually lost. Stalls on `out_ready` and a word offered while busy expose a design that advances without a handshake or captures a second word on top of the first.

// File: rtl/cf_pkg.sv
package cf_pkg;

  typedef enum logic {
    CF_IDLE = 1'b0,
    CF_EMIT = 1'b1
  } cf_state_e;

endpackage

// File: rtl/cf_edge_detect.sv
module cf_edge_detect #(
  parameter int STRIPS = 12
) (
  input  logic [STRIPS-1:0] hits,
  output logic [STRIPS-1:0] upper_edge,
  output logic [STRIPS-1:0] lower_edge
);

  logic [STRIPS-1:0] above;
  logic [STRIPS-1:0] below;

  for (genvar i = 0; i < STRIPS; i++) begin : g_nb
    if (i == STRIPS - 1) begin : g_top
      assign above[i] = 1'b0;
    end else begin : g_mid_hi
      assign above[i] = hits[i+1];
    end
    if (i == 0) begin : g_bot
      assign below[i] = 1'b0;
    end else begin : g_mid_lo
      assign below[i] = hits[i-1];
    end
  end

  assign upper_edge = hits & ~above;
  assign lower_edge = hits & ~below;

endmodule

// File: rtl/cf_top_select.sv
module cf_top_select #(
  parameter int STRIPS = 12,
  parameter int POS_W  = 4
) (
  input  logic [STRIPS-1:0] mask,
  output logic [POS_W-1:0]  pos,
  output logic [STRIPS-1:0] onehot
);

  always_comb begin
    pos    = '0;
    onehot = '0;
    for (int i = 0; i < STRIPS; i++) begin
      if (mask[i]) begin
        pos    = POS_W'(i + 1);
        onehot = STRIPS'(1) << i;
      end
    end
  end

endmodule

// File: rtl/cf_record_calc.sv
module cf_record_calc #(
  parameter int POS_W = 4,
  parameter int WID_W = 3
) (
  input  logic [POS_W-1:0] upper_pos,
  input  logic [POS_W-1:0] lower_pos,
  output logic [POS_W:0]   centre,
  output logic [WID_W-1:0] width
);

  localparam int WMAX = (1 << WID_W) - 1;

  logic [POS_W:0] span;

  always_comb begin
    centre = {1'b0, upper_pos} + {1'b0, lower_pos};
    span   = {1'b0, upper_pos} - {1'b0, lower_pos} + (POS_W+1)'(1);
    if (int'(span) > WMAX) width = WID_W'(WMAX);
    else                   width = span[WID_W-1:0];
  end

endmodule

// File: rtl/cluster_finder.sv
module cluster_finder #(
  parameter int STRIPS       = 12,
  parameter int MAX_CLUSTERS = 6,
  parameter int WID_W        = 3,
  localparam int POS_W = $clog2(STRIPS + 1),
  localparam int CNT_W = $clog2(MAX_CLUSTERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [STRIPS-1:0] in_hits,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [POS_W-1:0]  out_start,
  output logic [POS_W-1:0]  out_finish,
  output logic [POS_W:0]    out_centre,
  output logic [WID_W-1:0]  out_width,
  output logic              out_last,
  output logic              done,
  output logic              overflow
);
  import cf_pkg::*;

  cf_state_e         state_q;
  logic [STRIPS-1:0] up_q, lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, ovf_q;

  logic [STRIPS-1:0] up_new, lo_new;
  logic [STRIPS-1:0] up_oh, lo_oh, up_rem;
  logic [POS_W-1:0]  up_pos, lo_pos;
  logic              fire, final_rec;

  cf_edge_detect #(.STRIPS(STRIPS)) u_edges (
    .hits(in_hits), .upper_edge(up_new), .lower_edge(lo_new)
  );

  cf_top_select #(.STRIPS(STRIPS), .POS_W(POS_W)) u_sel_up (
    .mask(up_q), .pos(up_pos), .onehot(up_oh)
  );

  cf_top_select #(.STRIPS(STRIPS), .POS_W(POS_W)) u_sel_lo (
    .mask(lo_q), .pos(lo_pos), .onehot(lo_oh)
  );

  cf_record_calc #(.POS_W(POS_W), .WID_W(WID_W)) u_calc (
    .upper_pos(up_pos), .lower_pos(lo_pos), .centre(out_centre), .width(out_width)
  );

  assign busy       = (state_q == CF_EMIT);
  assign in_ready   = ~busy;
  assign out_valid  = busy;
  assign out_start  = up_pos;
  assign out_finish = lo_pos;
  assign up_rem     = up_q & ~up_oh;
  assign final_rec  = (up_rem == '0) || (cnt_q == CNT_W'(MAX_CLUSTERS - 1));
  assign out_last   = busy & final_rec;
  assign fire       = out_valid & out_ready;
  assign done       = done_q;
  assign overflow   = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CF_IDLE;
      up_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      case (state_q)
        CF_IDLE: begin
          if (in_valid) begin
            if (up_new != '0) begin
              up_q    <= up_new;
              lo_q    <= lo_new;
              cnt_q   <= '0;
              state_q <= CF_EMIT;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        default: begin
          if (fire) begin
            up_q  <= up_rem;
            lo_q  <= lo_q & ~lo_oh;
            cnt_q <= cnt_q + CNT_W'(1);
            if (final_rec) begin
              state_q <= CF_IDLE;
              done_q  <= 1'b1;
              ovf_q   <= (up_rem != '0);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cf_checker.sv
module cf_checker #(
  parameter int STRIPS = 12,
  parameter int POS_W  = 4,
  parameter int WID_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [POS_W-1:0] out_start,
  input logic [POS_W-1:0] out_finish,
  input logic [WID_W-1:0] out_width,
  input logic             done,
  input logic             overflow
);

  assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_finish != '0 && out_finish <= out_start));

  assert_descending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || out_start < $past(out_finish)));

  assert_width_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_width != '0);

  assert_ovf_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_start) && $stable(out_finish)));

endmodule

bind cluster_finder cf_checker #(.STRIPS(STRIPS), .POS_W(POS_W), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_start(out_start), .out_finish(out_finish), .out_width(out_width),
  .done(done), .overflow(overflow)
);

// File: tb/tb_cluster_finder.sv
`timescale 1ns/1ps
module tb_cluster_finder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drv_valid = 1'b0;
  logic [11:0] drv_hits = '0;
  logic        sel = 1'b0;
  logic        rdy = 1'b1;
  int          n_checks = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  logic       ir1, bs1, ov1, la1, dn1, of1;
  logic [3:0] st1, fi1;
  logic [4:0] ce1;
  logic [2:0] wd1;
  logic       ir2, bs2, ov2, la2, dn2, of2;
  logic [3:0] st2, fi2;
  logic [4:0] ce2;
  logic [2:0] wd2;

  cluster_finder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(drv_valid & ~sel), .in_ready(ir1),
    .in_hits(drv_hits), .busy(bs1), .out_valid(ov1), .out_ready(rdy),
    .out_start(st1), .out_finish(fi1), .out_centre(ce1), .out_width(wd1),
    .out_last(la1), .done(dn1), .overflow(of1)
  );

  cluster_finder #(.MAX_CLUSTERS(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .in_valid(drv_valid & sel), .in_ready(ir2),
    .in_hits(drv_hits), .busy(bs2), .out_valid(ov2), .out_ready(rdy),
    .out_start(st2), .out_finish(fi2), .out_centre(ce2), .out_width(wd2),
    .out_last(la2), .done(dn2), .overflow(of2)
  );

  wire       o_ready = sel ? ir2 : ir1;
  wire       o_valid = sel ? ov2 : ov1;
  wire       o_last  = sel ? la2 : la1;
  wire       o_done  = sel ? dn2 : dn1;
  wire       o_ovf   = sel ? of2 : of1;
  wire [3:0] o_start = sel ? st2 : st1;
  wire [3:0] o_fin   = sel ? fi2 : fi1;
  wire [4:0] o_cen   = sel ? ce2 : ce1;
  wire [2:0] o_wid   = sel ? wd2 : wd1;

  int exp_s[12];
  int exp_f[12];
  int exp_n;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference: walk the word from the top, collecting runs.
  task automatic model(input logic [11:0] w);
    int s;
    exp_n = 0;
    s = 0;
    for (int i = 11; i >= 0; i--) begin
      if (w[i] && (i == 11 || !w[i+1])) s = i + 1;
      if (w[i] && (i == 0 || !w[i-1])) begin
        exp_s[exp_n] = s;
        exp_f[exp_n] = i + 1;
        exp_n++;
      end
    end
  endtask

  task automatic run_word(input logic [11:0] w, input bit use2, input int lim);
    int k, n_exp, wexp;
    bit got_done, exp_ovf;
    model(w);
    n_exp   = (exp_n > lim) ? lim : exp_n;
    exp_ovf = (exp_n > lim);
    @(negedge clk);
    sel = use2;
    rdy = 1'b1;
    #0.1;
    chk(o_ready == 1'b1, "R1 ready when idle", int'(o_ready), 1);
    drv_valid = 1'b1;
    drv_hits  = w;
    @(posedge clk);
    #1 drv_valid = 1'b0;
    k = 0;
    got_done = 0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (o_done) begin
        got_done = 1;
        chk(k == n_exp, "R7 done after final record", k, n_exp);
        chk(o_ovf == exp_ovf, "R6 overflow flag", int'(o_ovf), int'(exp_ovf));
        break;
      end
      if (o_valid) begin
        if (k < n_exp) begin
          wexp = exp_s[k] - exp_f[k] + 1;
          if (wexp > 7) wexp = 7;
          chk(int'(o_start) == exp_s[k], "R2 start position", int'(o_start), exp_s[k]);
          chk(int'(o_fin) == exp_f[k], "R2 finish position", int'(o_fin), exp_f[k]);
          chk(int'(o_wid) == wexp, "R4 width", int'(o_wid), wexp);
          chk(int'(o_cen) == exp_s[k] + exp_f[k], "R5 centre", int'(o_cen), exp_s[k] + exp_f[k]);
          chk(o_last == (k == n_exp - 1), "R10 last flag", int'(o_last), int'(k == n_exp - 1));
        end else begin
          chk(1'b0, "R6 extra record past limit", k + 1, n_exp);
        end
        k++;
      end else begin
        chk(1'b0, "R3 idle gap before done", k, n_exp);
      end
    end
    chk(got_done, "R7 done pulse seen", int'(got_done), 1);
    @(negedge clk);
    chk(o_done == 1'b0, "R7 done lasts one cycle", int'(o_done), 0);
    chk(o_valid == 1'b0, "R3 no record after done", int'(o_valid), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(bs1 == 1'b0, "R9 busy after reset", int'(bs1), 0);
    chk(ov1 == 1'b0, "R9 out_valid after reset", int'(ov1), 0);
    chk(dn1 == 1'b0, "R9 done after reset", int'(dn1), 0);
    chk(of1 == 1'b0, "R9 overflow after reset", int'(of1), 0);
  endtask

  // Word 12'b110011000000: runs 12..11 and 8..7, consumer stalls first.
  task automatic test_backpressure();
    @(negedge clk);
    sel = 1'b0;
    rdy = 1'b0;
    drv_valid = 1'b1;
    drv_hits  = 12'b110011000000;
    @(posedge clk);
    #1 drv_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ov1 == 1'b1, "R8 valid held during stall", int'(ov1), 1);
      chk(st1 == 4'd12, "R8 start held during stall", int'(st1), 12);
    end
    rdy = 1'b1;
    @(negedge clk);
    chk(ov1 && st1 == 4'd8 && fi1 == 4'd7, "R8 second record after release", int'(st1), 8);
    @(negedge clk);
    chk(dn1 == 1'b1, "R7 done after stalled word", int'(dn1), 1);
  endtask

  // Word 12'b111000000111 is being emitted while 12'hFFF is offered.
  task automatic test_ignore_busy();
    @(negedge clk);
    sel = 1'b0;
    rdy = 1'b0;
    drv_valid = 1'b1;
    drv_hits  = 12'b111000000111;
    @(posedge clk);
    #1 drv_hits = 12'hFFF;
    @(negedge clk);
    chk(ir1 == 1'b0, "R1 in_ready low while busy", int'(ir1), 0);
    @(posedge clk);
    #1 drv_valid = 1'b0;
    rdy = 1'b1;
    @(negedge clk);
    chk(st1 == 4'd12 && fi1 == 4'd10, "R1 first word record 1 kept", int'(fi1), 10);
    @(negedge clk);
    chk(st1 == 4'd3 && fi1 == 4'd1, "R1 first word record 2 kept", int'(st1), 3);
    @(negedge clk);
    chk(dn1 == 1'b1, "R7 done for first word", int'(dn1), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ov1 == 1'b0, "R1 offered word ignored", int'(ov1), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    run_word(12'b011001110100, 1'b0, 6);
    run_word(12'b101010101010, 1'b0, 6);
    run_word(12'b100000000001, 1'b0, 6);
    run_word(12'hFFF,          1'b0, 6);
    run_word(12'b000001111111, 1'b0, 6);
    run_word(12'b000000111111, 1'b0, 6);
    run_word(12'h000,          1'b0, 6);
    run_word(12'b010101010101, 1'b0, 6);
    run_word(12'b101010000001, 1'b1, 2);
    run_word(12'b110000000011, 1'b1, 2);
    test_backpressure();
    test_ignore_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule